// File: doc/BRIEF.md
# TDM bit clock and frame-sync generator

This block produces the timing skeleton of a time-division-multiplexed audio link. It divides a master clock down to a serial bit clock, counts bits within a slot and slots within a frame, and shapes a frame-sync signal in one of four styles: slot-wide, half-frame, single-bit, or burst. In burst mode the frame stays parked until a sample is asked for. Serializers attached to the block follow its data position outputs and shift one bit on each strobe pulse.

The configuration inputs are static while the unit is enabled. The bit clock can come from an external pin instead of the divider. The frame sync can come from an external pin instead of the counters, and then a rising frame-sync edge realigns the counters. Data can start either on the frame-sync bit itself or one bit after it. Invert controls set the polarity of the frame-sync input, the frame-sync output and the bit-clock output.

All logic runs on the master clock. External pins are assumed to be already synchronous to that clock.

Top module: `tdm_clkgen`

## Requirements
- R1: `slot_code` sets the bits per slot to 8 × (code + 1): 0 gives 8, 1 gives 16, 2 gives 24 and 3 gives 32. `bit_idx` counts from 0 and wraps after the last bit of the slot.
- R2: A frame holds `nslots_m1` + 1 slots. `slot_idx` advances when `bit_idx` wraps, and returns to 0 after slot `nslots_m1`.
- R3: With the generated clock, each bit lasts `div_m1` + 1 master cycles. `sck_out` (before inversion) is low for the first part of the bit and high for its last floor((`div_m1`+1)/2) cycles. `bit_strobe` is high for one master cycle at the end of each bit. The position changes only after a strobe.
- R4: `fs_mode` 0: frame sync is high for the whole of slot 0.
- R5: `fs_mode` 1: frame sync is high for the first floor(F/2) bits of the frame, where F is the number of bits in a frame.
- R6: `fs_mode` 2: frame sync is high only during bit 0 of slot 0.
- R7: `fs_mode` 3 (burst): the counters stall at bit 0 of a slot until `burst_req` has been seen. Frame sync is high during that bit 0 only while a request is pending. While stalled, no strobe is produced.
- R8: With `one_bit_delay` = 1, the reported data position trails the frame position by one bit, modulo the frame length. So while frame sync marks bit 0 of slot 0, the outputs show the last bit of the last slot.
- R9: With `sck_from_pin` = 1, every falling edge of `sck_pin` gives one strobe, and `sck_out` follows `sck_pin`.
- R10: With `fs_from_pin` = 1, `fs_out` follows the (input-inverted) pin. A rising edge restarts the frame at slot 0, bit 0 on the next master cycle.
- R11: `fs_in_inv` inverts the frame-sync pin. `fs_out_inv` and `sck_out_inv` invert the two outputs.
- R12: While `enable` is 0, the positions are 0, `bit_strobe` is 0, and the outputs rest at their inactive levels (`fs_out` = `fs_out_inv`, `sck_out` = `sck_out_inv`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the unit; 0 parks everything |
| slot_code | input | 2 | Slot length code |
| nslots_m1 | input | 3 | Slots per frame minus one |
| fs_mode | input | 2 | Frame-sync shape: 0 slot, 1 half frame, 2 bit, 3 burst |
| one_bit_delay | input | 1 | Data starts one bit after frame sync |
| div_m1 | input | 5 | Bit-clock divide factor minus one |
| sck_from_pin | input | 1 | Take bit clock from `sck_pin` |
| fs_from_pin | input | 1 | Take frame sync from `fs_pin` |
| fs_in_inv | input | 1 | Invert the frame-sync pin |
| fs_out_inv | input | 1 | Invert `fs_out` |
| sck_out_inv | input | 1 | Invert `sck_out` |
| sck_pin | input | 1 | External bit clock |
| fs_pin | input | 1 | External frame sync |
| burst_req | input | 1 | Sample request in burst mode |
| sck_out | output | 1 | Bit clock |
| fs_out | output | 1 | Frame sync |
| bit_strobe | output | 1 | One-cycle pulse at each bit boundary |
| slot_idx | output | 3 | Slot of the current data bit |
| bit_idx | output | 5 | Bit within the slot of the current data bit |

## Verification
The bench measures whole frames for several combinations of slot size, slot count, divider and frame-sync shape. A miscounted wrap point or half-frame boundary shows up there as a wrong period or a wrong frame-sync high time. Burst mode is checked by holding off requests and then issuing exactly one. A design that does not stall would produce strobes while idle, and one that forgets to stall again would give more than one slot of strobes. The one-bit delay is checked at the frame-sync bit, where an off-by-one subtraction reports slot 0 instead of the last slot. The external-pin paths are checked by counting falling edges and by restarting the frame in the middle of a frame.

// File: rtl/tdm_clkgen_pkg.sv
// Shared encodings and helpers for the TDM clock generator.
// Assumes slot lengths are multiples of eight bits, up to 32.
package tdm_clkgen_pkg;
    localparam int SLOT_CODE_W   = 2;
    localparam int MAX_SLOT_BITS = 8 << SLOT_CODE_W;
    localparam int SB_W          = $clog2(MAX_SLOT_BITS + 1);
    localparam int BIT_W         = $clog2(MAX_SLOT_BITS);

    typedef enum logic [1:0] {
        FS_SLOT  = 2'd0,
        FS_HALF  = 2'd1,
        FS_BIT   = 2'd2,
        FS_BURST = 2'd3
    } fs_mode_e;

    // Bits per slot for a slot length code: 8 * (code + 1).
    function automatic logic [SB_W-1:0] slot_bits(input logic [SLOT_CODE_W-1:0] code);
        logic [SB_W-1:0] n;
        n = SB_W'(code) + SB_W'(1);
        return n << 3;
    endfunction
endpackage

// File: rtl/tdm_bitclk.sv
// Bit-clock source: divides the master clock or edge-detects an external
// bit-clock pin. Produces the bit-clock level and a one-cycle tick at each
// bit boundary (falling edge). Assumes sck_pin is synchronous to clk.
module tdm_bitclk #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sck_from_pin,
    input  logic [DIV_W-1:0] div_m1,
    input  logic             sck_pin,
    output logic             sck_level,
    output logic             tick
);
    logic [DIV_W-1:0] div_cnt;
    logic             sck_q;
    logic             gen_level;

    // Divider counter: 0 .. div_m1, parked at zero when not generating.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || sck_from_pin)
            div_cnt <= '0;
        else if (div_cnt >= div_m1)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end

    // Previous pin level, for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            sck_q <= 1'b0;
        else
            sck_q <= sck_pin;
    end

    // Level and tick selection between generated and pin clock.
    always_comb begin
        gen_level = div_cnt > (div_m1 >> 1);
        if (sck_from_pin) begin
            sck_level = en && sck_pin;
            tick      = en && sck_q && !sck_pin;
        end else begin
            sck_level = en && gen_level;
            tick      = en && (div_cnt >= div_m1);
        end
    end
endmodule

// File: rtl/tdm_frame_ctr.sv
// Frame position counters (bit within slot, slot within frame), burst
// stall logic and realignment on an external frame-sync edge.
// Assumes the configuration is stable while en is high.
module tdm_frame_ctr
    import tdm_clkgen_pkg::*;
#(
    parameter int NSLOT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   tick,
    input  logic [SLOT_CODE_W-1:0] slot_code,
    input  logic [NSLOT_W-1:0]     nslots_m1,
    input  logic                   burst_mode,
    input  logic                   burst_req,
    input  logic                   ext_fs,
    input  logic                   fs_now,
    output logic [BIT_W-1:0]       fbit,
    output logic [NSLOT_W-1:0]     fslot,
    output logic                   pend,
    output logic                   adv
);
    logic [BIT_W-1:0] last_bit;
    logic             hold;
    logic             fs_q;
    logic             restart;

    // Stall and advance decisions for the current cycle.
    always_comb begin
        last_bit = BIT_W'(slot_bits(slot_code) - 1'b1);
        hold     = burst_mode && (fbit == '0) && !pend;
        adv      = en && tick && !hold;
        restart  = en && ext_fs && fs_now && !fs_q;
    end

    // External frame-sync level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !ext_fs)
            fs_q <= 1'b0;
        else
            fs_q <= fs_now;
    end

    // Bit and slot counters with wrap and restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart) begin
            fbit  <= '0;
            fslot <= '0;
        end else if (adv) begin
            if (fbit >= last_bit) begin
                fbit  <= '0;
                fslot <= (fslot >= nslots_m1) ? '0 : fslot + 1'b1;
            end else begin
                fbit <= fbit + 1'b1;
            end
        end
    end

    // Pending burst request; consumed when a sample leaves bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !burst_mode)
            pend <= 1'b0;
        else if (adv && (fbit == '0))
            pend <= burst_req;
        else
            pend <= pend | burst_req;
    end
endmodule

// File: rtl/tdm_fs_shaper.sv
// Combinational frame-sync shaping from the frame position, and the data
// position seen by serializers (frame position minus the optional delay).
module tdm_fs_shaper
    import tdm_clkgen_pkg::*;
#(
    parameter int NSLOT_W = 3
) (
    input  logic                   en,
    input  logic [1:0]             fs_mode,
    input  logic                   ext_fs,
    input  logic                   fs_now,
    input  logic                   pend,
    input  logic                   one_bit_delay,
    input  logic [SLOT_CODE_W-1:0] slot_code,
    input  logic [NSLOT_W-1:0]     nslots_m1,
    input  logic [BIT_W-1:0]       fbit,
    input  logic [NSLOT_W-1:0]     fslot,
    output logic                   fs_core,
    output logic [NSLOT_W-1:0]     data_slot,
    output logic [BIT_W-1:0]       data_bit
);
    localparam int TOT_W = SB_W + NSLOT_W;

    logic [SB_W-1:0]  sb;
    logic [TOT_W-1:0] pos;
    logic [TOT_W-1:0] total;
    logic             fs_gen;

    // Frame-sync level for the selected shape.
    always_comb begin
        sb    = slot_bits(slot_code);
        pos   = TOT_W'(fslot) * TOT_W'(sb) + TOT_W'(fbit);
        total = (TOT_W'(nslots_m1) + TOT_W'(1)) * TOT_W'(sb);
        unique case (fs_mode_e'(fs_mode))
            FS_SLOT:  fs_gen = (fslot == '0);
            FS_HALF:  fs_gen = pos < (total >> 1);
            FS_BIT:   fs_gen = (fslot == '0) && (fbit == '0);
            default:  fs_gen = (fbit == '0) && pend;
        endcase
        fs_core = en && (ext_fs ? fs_now : fs_gen);
    end

    // Data position: equal to the frame position, or one bit behind it.
    always_comb begin
        data_slot = fslot;
        data_bit  = fbit;
        if (!en) begin
            data_slot = '0;
            data_bit  = '0;
        end else if (one_bit_delay) begin
            if (fbit != '0) begin
                data_bit = fbit - 1'b1;
            end else begin
                data_bit  = BIT_W'(sb - 1'b1);
                data_slot = (fslot == '0) ? nslots_m1 : fslot - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdm_clkgen.sv
// Top of the TDM bit-clock and frame-sync generator. Wires the bit-clock
// source, frame counters and frame-sync shaper, and applies polarity.
// Assumes static configuration while enabled and pins synchronous to clk.
module tdm_clkgen
    import tdm_clkgen_pkg::*;
#(
    parameter int DIV_W   = 5,
    parameter int NSLOT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [1:0]         slot_code,
    input  logic [NSLOT_W-1:0] nslots_m1,
    input  logic [1:0]         fs_mode,
    input  logic               one_bit_delay,
    input  logic [DIV_W-1:0]   div_m1,
    input  logic               sck_from_pin,
    input  logic               fs_from_pin,
    input  logic               fs_in_inv,
    input  logic               fs_out_inv,
    input  logic               sck_out_inv,
    input  logic               sck_pin,
    input  logic               fs_pin,
    input  logic               burst_req,
    output logic               sck_out,
    output logic               fs_out,
    output logic               bit_strobe,
    output logic [NSLOT_W-1:0] slot_idx,
    output logic [BIT_W-1:0]   bit_idx
);
    logic               sck_level;
    logic               tick;
    logic               fs_now;
    logic               burst_mode;
    logic [BIT_W-1:0]   fbit;
    logic [NSLOT_W-1:0] fslot;
    logic               pend;
    logic               adv;
    logic               fs_core;

    // Input polarity and burst qualification.
    always_comb begin
        fs_now     = fs_pin ^ fs_in_inv;
        burst_mode = (fs_mode_e'(fs_mode) == FS_BURST) && !fs_from_pin;
    end

    tdm_bitclk #(.DIV_W(DIV_W)) u_bitclk (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (enable),
        .sck_from_pin (sck_from_pin),
        .div_m1       (div_m1),
        .sck_pin      (sck_pin),
        .sck_level    (sck_level),
        .tick         (tick)
    );

    tdm_frame_ctr #(.NSLOT_W(NSLOT_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (enable),
        .tick       (tick),
        .slot_code  (slot_code),
        .nslots_m1  (nslots_m1),
        .burst_mode (burst_mode),
        .burst_req  (burst_req),
        .ext_fs     (fs_from_pin),
        .fs_now     (fs_now),
        .fbit       (fbit),
        .fslot      (fslot),
        .pend       (pend),
        .adv        (adv)
    );

    tdm_fs_shaper #(.NSLOT_W(NSLOT_W)) u_shaper (
        .en            (enable),
        .fs_mode       (fs_mode),
        .ext_fs        (fs_from_pin),
        .fs_now        (fs_now),
        .pend          (pend),
        .one_bit_delay (one_bit_delay),
        .slot_code     (slot_code),
        .nslots_m1     (nslots_m1),
        .fbit          (fbit),
        .fslot         (fslot),
        .fs_core       (fs_core),
        .data_slot     (slot_idx),
        .data_bit      (bit_idx)
    );

    // Output polarity and strobe.
    always_comb begin
        sck_out    = sck_level ^ sck_out_inv;
        fs_out     = fs_core ^ fs_out_inv;
        bit_strobe = adv;
    end
endmodule

// File: rtl/tdm_clkgen_chk.sv
// Property checker for tdm_clkgen, attached by bind. Observes ports only.
module tdm_clkgen_chk
    import tdm_clkgen_pkg::*;
#(
    parameter int DIV_W   = 5,
    parameter int NSLOT_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic [1:0]         slot_code,
    input logic [NSLOT_W-1:0] nslots_m1,
    input logic [1:0]         fs_mode,
    input logic               one_bit_delay,
    input logic [DIV_W-1:0]   div_m1,
    input logic               sck_from_pin,
    input logic               fs_from_pin,
    input logic               fs_in_inv,
    input logic               fs_out_inv,
    input logic               sck_out_inv,
    input logic               sck_pin,
    input logic               fs_pin,
    input logic               burst_req,
    input logic               sck_out,
    input logic               fs_out,
    input logic               bit_strobe,
    input logic [NSLOT_W-1:0] slot_idx,
    input logic [BIT_W-1:0]   bit_idx
);
    p_bit_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        32'(bit_idx) < 32'(slot_bits(slot_code)));

    p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx <= nslots_m1);

    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && bit_strobe && (sck_from_pin || div_m1 != '0)) |=> !bit_strobe);

    p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !bit_strobe && !fs_from_pin) |=> (!enable || $stable(bit_idx)));

    p_bit_fs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && fs_mode == 2'd2 && !fs_from_pin && !one_bit_delay && (fs_out != fs_out_inv))
        |-> (slot_idx == '0 && bit_idx == '0));

    p_burst_fs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && fs_mode == 2'd3 && !fs_from_pin && !one_bit_delay && (fs_out != fs_out_inv))
        |-> (bit_idx == '0));

    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!bit_strobe && slot_idx == '0 && bit_idx == '0
                     && fs_out == fs_out_inv && sck_out == sck_out_inv));
endmodule

bind tdm_clkgen tdm_clkgen_chk #(.DIV_W(DIV_W), .NSLOT_W(NSLOT_W)) chk_i (.*);

// File: tb/tdm_clkgen_tb_top.sv
`timescale 1ns/1ps
module tdm_clkgen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] slot_code = '0;
    logic [2:0] nslots_m1 = '0;
    logic [1:0] fs_mode = '0;
    logic       one_bit_delay = 1'b0;
    logic [4:0] div_m1 = '0;
    logic       sck_from_pin = 1'b0;
    logic       fs_from_pin = 1'b0;
    logic       fs_in_inv = 1'b0;
    logic       fs_out_inv = 1'b0;
    logic       sck_out_inv = 1'b0;
    logic       sck_pin = 1'b0;
    logic       fs_pin = 1'b0;
    logic       burst_req = 1'b0;
    logic       sck_out;
    logic       fs_out;
    logic       bit_strobe;
    logic [2:0] slot_idx;
    logic [4:0] bit_idx;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    tdm_clkgen dut_i (.*);

    // Columns: slot_code, nslots_m1, fs_mode, div_m1,
    //          frame period (cycles), fs high cycles, strobes, sck high cycles
    localparam int NV = 5;
    localparam int VTAB [0:NV-1][0:7] = '{
        '{0, 1, 0, 1,  32,  16,  16, 16},
        '{1, 0, 1, 3,  64,  32,  16, 32},
        '{3, 7, 2, 0, 256,   1, 256,  0},
        '{2, 2, 1, 2, 216, 108,  72, 72},
        '{0, 2, 0, 4, 120,  40,  24, 48}
    };

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic setup(input int code, input int ns, input int mode,
                         input int dly, input int dv);
        @(posedge clk); #1;
        enable        = 1'b0;
        slot_code     = 2'(code);
        nslots_m1     = 3'(ns);
        fs_mode       = 2'(mode);
        one_bit_delay = 1'(dly);
        div_m1        = 5'(dv);
        @(posedge clk); #1;
        enable = 1'b1;
    endtask

    // Wait for a frame-sync rise, then measure until the next one.
    task automatic measure(output int per, output int hi, output int stb, output int skh);
        logic prev;
        int   guard;
        per = 0; hi = 0; stb = 0; skh = 0; guard = 0;
        @(negedge clk);
        prev = fs_out;
        @(negedge clk);
        while (!(fs_out && !prev) && guard < 2000) begin
            prev = fs_out; guard++;
            @(negedge clk);
        end
        do begin
            per++;
            hi  += int'(fs_out);
            stb += int'(bit_strobe);
            skh += int'(sck_out);
            prev = fs_out;
            @(negedge clk);
        end while (!(fs_out && !prev) && per < 2000);
    endtask

    initial begin : watchdog
        #(150000 * 5);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int per, hi, stb, skh, n, guard;
        logic prev;

        // Reset state (R12)
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check_eq("R12 reset fs_out", int'(fs_out), 0);
        check_eq("R12 reset sck_out", int'(sck_out), 0);
        check_eq("R12 reset strobe", int'(bit_strobe), 0);
        check_eq("R12 reset position", int'({slot_idx, bit_idx}), 0);

        // Table of frame shapes (R1..R6 across the columns)
        for (int v = 0; v < NV; v++) begin
            setup(VTAB[v][0], VTAB[v][1], VTAB[v][2], 0, VTAB[v][3]);
            measure(per, hi, stb, skh);
            check_eq($sformatf("R1/R2/R3 frame period v%0d", v), per, VTAB[v][4]);
            check_eq($sformatf("R4/R5/R6 fs high v%0d", v), hi, VTAB[v][5]);
            check_eq($sformatf("R1/R2 strobes v%0d", v), stb, VTAB[v][6]);
            check_eq($sformatf("R3 sck high v%0d", v), skh, VTAB[v][7]);
        end

        // Single-bit sync, no delay: position at sync is origin (R6)
        setup(0, 1, 2, 0, 1);
        guard = 0;
        @(negedge clk);
        while (!fs_out && guard < 500) begin guard++; @(negedge clk); end
        check_eq("R6 position at sync slot", int'(slot_idx), 0);
        check_eq("R6 position at sync bit", int'(bit_idx), 0);

        // One-bit delay: data trails frame by one bit (R8)
        setup(0, 1, 2, 1, 1);
        guard = 0;
        @(negedge clk);
        while (!fs_out && guard < 500) begin guard++; @(negedge clk); end
        check_eq("R8 delayed slot at sync", int'(slot_idx), 1);
        check_eq("R8 delayed bit at sync", int'(bit_idx), 7);

        // Burst mode: idle without request, one slot per request (R7)
        setup(0, 0, 3, 0, 1);
        stb = 0; hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            stb += int'(bit_strobe);
            hi  += int'(fs_out);
        end
        check_eq("R7 idle strobes", stb, 0);
        check_eq("R7 idle fs high", hi, 0);
        stb = 0; n = 0; prev = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); #1;
            burst_req = (i == 0);
            @(negedge clk);
            stb += int'(bit_strobe);
            if (fs_out && !prev) n++;
            prev = fs_out;
        end
        check_eq("R7 one request strobes", stb, 8);
        check_eq("R7 one request fs pulses", n, 1);
        check_eq("R7 parked at bit 0", int'(bit_idx), 0);

        // External bit clock (R9)
        setup(0, 1, 2, 0, 1);
        @(posedge clk); #1;
        enable = 1'b0;
        sck_from_pin = 1'b1;
        sck_pin = 1'b0;
        @(posedge clk); #1;
        enable = 1'b1;
        stb = 0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1 sck_pin = 1'b1;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                stb += int'(bit_strobe);
                if (i == 0 && k == 0) check_eq("R9 sck_out follows pin", int'(sck_out), 1);
            end
            @(posedge clk); #1 sck_pin = 1'b0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                stb += int'(bit_strobe);
            end
        end
        check_eq("R9 strobes per falling edge", stb, 10);
        check_eq("R9 bit after ten edges", int'(bit_idx), 2);
        check_eq("R9 slot after ten edges", int'(slot_idx), 1);
        @(posedge clk); #1;
        enable = 1'b0;
        sck_from_pin = 1'b0;

        // External frame sync restarts the frame (R10, R11)
        setup(1, 1, 0, 0, 1);
        @(posedge clk); #1;
        enable = 1'b0;
        fs_from_pin = 1'b1;
        fs_pin = 1'b0;
        @(posedge clk); #1;
        enable = 1'b1;
        repeat (37) @(negedge clk);
        check_eq("R10 fs_out low before pin edge", int'(fs_out), 0);
        @(posedge clk); #1 fs_pin = 1'b1;
        @(negedge clk);
        check_eq("R10 fs_out follows pin", int'(fs_out), 1);
        @(negedge clk);
        check_eq("R10 restart slot", int'(slot_idx), 0);
        check_eq("R10 restart bit", int'(bit_idx), 0);
        @(posedge clk); #1;
        fs_pin = 1'b0;
        fs_in_inv = 1'b1;
        @(negedge clk);
        check_eq("R11 input inversion", int'(fs_out), 1);
        @(posedge clk); #1 fs_out_inv = 1'b1;
        @(negedge clk);
        check_eq("R11 output inversion", int'(fs_out), 0);
        @(posedge clk); #1;
        enable = 1'b0;
        fs_from_pin = 1'b0;
        fs_in_inv = 1'b0;
        fs_out_inv = 1'b0;

        // Disable mid-frame (R12)
        setup(0, 1, 0, 0, 1);
        repeat (21) @(negedge clk);
        @(posedge clk); #1 enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_eq("R12 disabled strobe", int'(bit_strobe), 0);
        check_eq("R12 disabled position", int'({slot_idx, bit_idx}), 0);
        check_eq("R12 disabled fs_out", int'(fs_out), 0);
        check_eq("R12 disabled sck_out", int'(sck_out), 0);

        // Inactive levels follow the output inversions (R11, R12)
        @(posedge clk); #1;
        fs_out_inv = 1'b1;
        sck_out_inv = 1'b1;
        @(negedge clk);
        check_eq("R11 idle fs_out inverted", int'(fs_out), 1);
        check_eq("R12 idle sck_out inverted", int'(sck_out), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule